// File: doc/BRIEF.md
# Delta-Sample Fetch Controller

This block is the memory-fetch and control half of a delta-modulation audio channel. The CPU programs it through a byte-wide write port that holds four registers: mode/rate, start address, sample length and control. Once the channel is enabled, a programmable rate timer asks for one sample byte from memory per period. The block walks a 15-bit address pointer and a 12-bit length counter, and at the end of a sample it stops, loops or raises an interrupt, as the mode selects. A combinational status byte reports the interrupt flag and the active state.

Memory reads use a plain request/acknowledge pair, with at most one request outstanding. Fetched bytes go downstream on a valid/ready stream held in a one-byte output buffer. Back-pressure rule: while `out_valid` is high and `out_ready` is low, the byte and `out_valid` hold. A full buffer also blocks the next memory request. A timer expiry during that wait is kept pending, and later expiries are merged into it. The shifter, the delta counter and the DAC lie downstream and are not part of this block.

Write-port register select (`wr_sel`): 0 is mode/rate, 1 is start address, 2 is length, 3 is control/status.

Top module: `dsamp_fetch`

## Requirements
- R1: `status_o` reads the interrupt flag in bit 7 and the active state in bit 4; all other bits read 0. Reading never changes any state.
- R2: With the output accepted and memory acknowledging promptly, successive memory requests are exactly P clocks apart. P is selected by mode bits 3:0, index 0..15 → 3424, 3040, 2720, 2560, 2288, 2032, 1808, 1712, 1520, 1280, 1136, 1024, 848, 672, 576, 432.
- R3: A sample's first fetch address is C000h + (start register × 64). Each later fetch of the same pass uses the previous address + 1.
- R4: The address after FFFFh is 8000h.
- R5: A sample is (length register × 16) + 1 bytes long. In end mode 00 (mode bits 7:6), the channel goes inactive after the last byte and the interrupt flag stays 0.
- R6: In a loop mode (mode bit 6 = 1), the fetch after the last byte restarts at the start address with the full length. The channel stays active and the flag stays 0.
- R7: In end mode 10, the flag and the `irq` output go high when the last byte is acknowledged, and the channel goes inactive. The flag stays set through reads and idle cycles.
- R8: The flag is cleared by any control-register write, and by a mode write whose bit 7 is 0. A mode write with bit 7 = 1 leaves it set.
- R9: A control write with bit 4 = 1 while the channel is inactive reloads the pointer and the length and starts the channel. The same write while the channel is active changes nothing. A control write with bit 4 = 0 stops the channel, and no further requests follow.
- R10: Reset clears the flag, makes the channel inactive, and drops `mem_req` and `out_valid`. The mode, start-address and length registers keep their values.
- R11: `mem_req` stays high with a stable `mem_addr` until `mem_ack`. The pointer advances only on the acknowledge. An expiry while a request is pending is held, not lost.
- R12: `out_valid` and `out_data` hold while `out_ready` is low. No memory request starts while the output buffer is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock; the timer counts one per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 mode, 1 address, 2 length, 3 control) |
| wr_data | input | 8 | Register write data |
| status_o | output | 8 | Status byte: bit 7 interrupt flag, bit 4 active |
| irq | output | 1 | Level interrupt, high while the flag is set |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_ack | input | 1 | Memory acknowledge, data valid |
| mem_data | input | 8 | Memory read data |
| out_valid | output | 1 | Fetched byte available |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Fetched byte |

## Verification
On every cycle, the assertions check:
- the request/acknowledge hold and address stability;
- the output hold under back-pressure, and that no request starts while the buffer is full;
- that the flag is only ever raised from end mode 10 and persists without writes;
- that every fetch address lies in the upper half of memory;
- that timer expiries are single pulses.

Only the bench scenarios can show:
- the exact fetch period for each of the sixteen rate indices;
- the address arithmetic and its wrap from FFFFh to 8000h;
- the byte count per sample and the reload in loop mode;
- the flag-clearing rules;
- register retention across reset.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
  localparam int RATE_W = 12;

  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_LEN  = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  function automatic logic [RATE_W-1:0] fetch_period(input logic [3:0] idx);
    logic [RATE_W-1:0] p;
    case (idx)
      4'h0: p = 12'hD60;  4'h1: p = 12'hBE0;  4'h2: p = 12'hAA0;  4'h3: p = 12'hA00;
      4'h4: p = 12'h8F0;  4'h5: p = 12'h7F0;  4'h6: p = 12'h710;  4'h7: p = 12'h6B0;
      4'h8: p = 12'h5F0;  4'h9: p = 12'h500;  4'hA: p = 12'h470;  4'hB: p = 12'h400;
      4'hC: p = 12'h350;  4'hD: p = 12'h2A0;  4'hE: p = 12'h240;  default: p = 12'h1B0;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/dsf_regs.sv
module dsf_regs #(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] mode_q,
  output logic [REG_W-1:0] base_q,
  output logic [REG_W-1:0] len_q,
  output logic             mode_wr,
  output logic             ctrl_wr
);
  import dsf_pkg::*;

  assign mode_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_MODE);
  assign ctrl_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);

  // Configuration registers deliberately have no reset: they survive it.
  always_ff @(posedge clk) begin
    if (mode_wr) mode_q <= wr_data;
    if (wr_en && reg_sel_e'(wr_sel) == SEL_ADDR) base_q <= wr_data;
    if (wr_en && reg_sel_e'(wr_sel) == SEL_LEN)  len_q  <= wr_data;
  end
endmodule

// File: rtl/dsf_rate_timer.sv
module dsf_rate_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         run,
  input  logic [W-1:0] period,
  output logic         expire
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] reload;

  assign reload = period - 1'b1;
  assign expire = run && !load && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (load)    cnt_q <= reload;
    else if (run) begin
      if (cnt_q == '0) cnt_q <= reload;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  // R2
  single_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);
endmodule

// File: rtl/dsf_cursor.sv
module dsf_cursor #(
  parameter int PTR_W = 15,
  parameter int LEN_W = 12,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             load,
  input  logic             advance,
  input  logic [REG_W-1:0] base_reg,
  input  logic [REG_W-1:0] len_reg,
  output logic [PTR_W-1:0] ptr,
  output logic             last
);
  localparam int BASE_SH = PTR_W - 1 - REG_W;
  localparam int LEN_SH  = LEN_W - REG_W;

  logic [LEN_W-1:0] left_q;

  assign last = (left_q == '0);

  always_ff @(posedge clk) begin
    if (load) begin
      ptr    <= {1'b1, base_reg, {BASE_SH{1'b0}}};
      left_q <= {len_reg, {LEN_SH{1'b0}}};
    end else if (advance) begin
      ptr    <= ptr + 1'b1;
      left_q <= left_q - 1'b1;
    end
  end

  // R11
  load_adv_excl_chk: assert property (@(posedge clk) !(load && advance));
endmodule

// File: rtl/dsamp_fetch.sv
module dsamp_fetch #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 15,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [7:0]        wr_data,
  output logic [7:0]        status_o,
  output logic              irq,
  output logic              mem_req,
  output logic [PTR_W:0]    mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  import dsf_pkg::*;
  localparam int ADDR_W = PTR_W + 1;

  logic [7:0] mode_q, base_q, len_q;
  logic       mode_wr, ctrl_wr;
  logic       expire, last;
  logic [PTR_W-1:0] ptr;

  logic active_q, pend_q, drop_q, irq_q;
  logic start, stop, ack_take, ack_live, issue, ld_cur, adv_cur;
  logic loop_m, irq_m;

  dsf_regs #(.REG_W(8)) u_regs (
    .clk(clk), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .mode_q(mode_q), .base_q(base_q), .len_q(len_q),
    .mode_wr(mode_wr), .ctrl_wr(ctrl_wr)
  );

  dsf_rate_timer #(.W(RATE_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(start), .run(active_q),
    .period(fetch_period(mode_q[3:0])), .expire(expire)
  );

  dsf_cursor #(.PTR_W(PTR_W), .LEN_W(LEN_W), .REG_W(8)) u_cursor (
    .clk(clk), .load(ld_cur), .advance(adv_cur),
    .base_reg(base_q), .len_reg(len_q), .ptr(ptr), .last(last)
  );

  assign loop_m   = mode_q[6];
  assign irq_m    = mode_q[7] && !mode_q[6];
  assign start    = ctrl_wr && wr_data[4] && !active_q;
  assign stop     = ctrl_wr && !wr_data[4];
  assign ack_take = mem_req && mem_ack;
  assign ack_live = ack_take && !drop_q && active_q && !stop;
  assign issue    = active_q && pend_q && !mem_req && !out_valid;
  assign ld_cur   = start || (ack_live && last && loop_m);
  assign adv_cur  = ack_live && !last;

  assign status_o = {irq_q, 2'b00, active_q, 4'b0000};
  assign irq      = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      pend_q    <= 1'b0;
      drop_q    <= 1'b0;
      irq_q     <= 1'b0;
      mem_req   <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      if (stop)                               active_q <= 1'b0;
      else if (start)                         active_q <= 1'b1;
      else if (ack_live && last && !loop_m)   active_q <= 1'b0;

      if (start || stop)  pend_q <= 1'b0;
      else if (expire)    pend_q <= 1'b1;
      else if (issue)     pend_q <= 1'b0;

      if (ack_take)                mem_req <= 1'b0;
      else if (issue)              mem_req <= 1'b1;

      if (ack_take)                drop_q <= 1'b0;
      else if (stop && mem_req)    drop_q <= 1'b1;

      if (ack_live)                out_valid <= 1'b1;
      else if (out_ready)          out_valid <= 1'b0;

      if (ack_live && last && irq_m)               irq_q <= 1'b1;
      else if (ctrl_wr || (mode_wr && !wr_data[7])) irq_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (issue)    mem_addr <= ADDR_W'({1'b1, ptr});
    if (ack_live) out_data <= mem_data;
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  // R12
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R12
  no_req_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> !$past(out_valid));
  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(mode_q[7:6]) == 2'b10);
  // R7
  irq_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !wr_en |=> irq);
  // R4
  upper_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[PTR_W]);
endmodule

// File: tb/tb_dsamp_fetch.sv
`timescale 1ns/100ps
module tb_dsamp_fetch;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, wr_en = 1'b0, mem_ack = 1'b0, out_ready = 1'b1;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0, mem_data = '0, status_o, out_data;
  logic irq, mem_req, out_valid;
  logic [15:0] mem_addr;

  dsamp_fetch dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .status_o(status_o), .irq(irq), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_data(mem_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  localparam int PER [16] = '{3424, 3040, 2720, 2560, 2288, 2032, 1808, 1712,
                              1520, 1280, 1136, 1024, 848, 672, 576, 432};

  int errs = 0, checks = 0, cyc = 0;
  int n_log = 0, n_out = 0, data_bad = 0, hold_bad = 0, ack_lat = 0, wait_c = 0;
  logic [15:0] log_a [0:255];
  int          log_t [0:255];
  logic [15:0] held_a, last_a;

  function automatic logic [7:0] fdat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // memory model and stream monitor, all on the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
      wait_c  = 0;
    end else begin
      if (out_valid && out_ready) begin
        n_out++;
        if (out_data != fdat(last_a)) data_bad++;
      end
      if (mem_req && !mem_ack) begin
        if (wait_c == 0) held_a = mem_addr;
        else if (mem_addr != held_a) hold_bad++;
        if (wait_c >= ack_lat) begin
          mem_ack  = 1'b1;
          mem_data = fdat(mem_addr);
          last_a   = mem_addr;
          log_a[n_log % 256] = mem_addr;
          log_t[n_log % 256] = cyc;
          n_log++;
          wait_c = 0;
        end else wait_c++;
      end else mem_ack = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_log(input int n, input int lim);
    for (int i = 0; i < lim && n_log < n; i++) @(negedge clk);
  endtask

  task automatic wait_idle(input int lim);
    for (int i = 0; i < lim && status_o[4]; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic setup(input logic [7:0] m, input logic [7:0] a, input logic [7:0] l);
    wr(2'd0, m); wr(2'd1, a); wr(2'd2, l);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int b, bo, bd, bh;
    logic [15:0] base;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(status_o == 8'h00 && !mem_req && !out_valid && !irq, "R10 reset state", status_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 sweep of every rate index, looping one-byte sample
    for (int r = 0; r < 16; r++) begin
      setup(8'h40 | 8'(r), 8'h00, 8'h00);
      b = n_log;
      wr(2'd3, 8'h10);
      wait_log(b + 2, 8000);
      chk(log_t[(b+1)%256] - log_t[b%256] == PER[r], "R2 fetch period",
          log_t[(b+1)%256] - log_t[b%256], PER[r]);
      wr(2'd3, 8'h00);
      repeat (4) @(negedge clk);
    end

    // R3 / R5: one-shot, 17 bytes from C940
    setup(8'h0F, 8'h25, 8'h01);
    b = n_log; bo = n_out; bd = data_bad;
    wr(2'd3, 8'h10);
    repeat (2) @(negedge clk);
    // R1 status while playing
    chk(status_o == 8'h10, "R1 status active", status_o, 8'h10);
    wait_idle(20000);
    chk(n_log - b == 17, "R5 byte count", n_log - b, 17);
    begin
      int bad = 0;
      for (int i = 0; i < 17; i++)
        if (log_a[(b+i)%256] != 16'hC940 + 16'(i)) bad++;
      chk(bad == 0, "R3 address sequence", bad, 0);
    end
    chk(status_o == 8'h00 && !irq, "R5 end mode 00 inactive no irq", status_o, 0);
    chk(n_out - bo == 17 && data_bad == bd, "R12 stream bytes", n_out - bo, 17);

    // R4 / R7: IRQ mode, 65 bytes from FFC0, wraps to 8000
    setup(8'h8F, 8'hFF, 8'h04);
    b = n_log;
    wr(2'd3, 8'h10);
    wait_idle(60000);
    chk(n_log - b == 65, "R5 byte count 65", n_log - b, 65);
    chk(log_a[(b+63)%256] == 16'hFFFF, "R3 last high address", log_a[(b+63)%256], 16'hFFFF);
    chk(log_a[(b+64)%256] == 16'h8000, "R4 wrap address", log_a[(b+64)%256], 16'h8000);
    chk(status_o == 8'h80 && irq, "R7 irq set, inactive", status_o, 8'h80);
    repeat (20) @(negedge clk);
    chk(irq && status_o[7], "R7 irq held through reads", irq, 1);
    // R8 mode write with bit 7 = 1 keeps flag; bit 7 = 0 clears
    wr(2'd0, 8'h8F);
    @(negedge clk);
    chk(irq, "R8 mode write bit7=1 keeps flag", irq, 1);
    wr(2'd0, 8'h0F);
    @(negedge clk);
    chk(!irq && status_o == 8'h00, "R8 mode write bit7=0 clears", status_o, 0);
    // R8 control write clears
    setup(8'h8F, 8'h00, 8'h00);
    wr(2'd3, 8'h10);
    wait_idle(2000);
    chk(irq, "R7 irq after single byte", irq, 1);
    wr(2'd3, 8'h00);
    @(negedge clk);
    chk(!irq, "R8 control write clears", irq, 0);

    // R6 / R9: loop of 17 bytes, redundant enable mid-pass
    setup(8'hCF, 8'h08, 8'h01);
    base = 16'hC200;
    b = n_log;
    wr(2'd3, 8'h10);
    wait_log(b + 5, 5000);
    wr(2'd3, 8'h10);
    wait_log(b + 19, 20000);
    begin
      int bad = 0;
      for (int i = 0; i < 19; i++)
        if (log_a[(b+i)%256] != base + 16'(i % 17)) bad++;
      chk(bad == 0, "R6/R9 loop reload, enable while active ignored", bad, 0);
    end
    chk(status_o == 8'h10 && !irq, "R6 loop stays active no irq", status_o, 8'h10);
    wr(2'd3, 8'h00);
    bo = n_log;
    repeat (1000) @(negedge clk);
    chk(n_log == bo && status_o == 8'h00, "R9 stop halts fetches", n_log - bo, 0);

    // R12 back-pressure
    setup(8'h4F, 8'h00, 8'h00);
    out_ready = 1'b0;
    b = n_log;
    wr(2'd3, 8'h10);
    repeat (1400) @(negedge clk);
    chk(n_log - b == 1, "R12 full buffer blocks fetch", n_log - b, 1);
    chk(out_valid && out_data == fdat(16'hC000), "R12 held byte", out_data, fdat(16'hC000));
    out_ready = 1'b1;
    wait_log(b + 2, 2000);
    chk(n_log - b == 2, "R12 fetch resumes after accept", n_log - b, 2);
    wr(2'd3, 8'h00);
    repeat (4) @(negedge clk);

    // R11 slow memory, expiry during a pending request
    ack_lat = 500;
    setup(8'h0F, 8'h02, 8'h01);
    b = n_log; bh = hold_bad;
    wr(2'd3, 8'h10);
    wait_idle(30000);
    begin
      int bad = 0;
      for (int i = 0; i < 17; i++)
        if (log_a[(b+i)%256] != 16'hC080 + 16'(i)) bad++;
      chk(bad == 0 && n_log - b == 17, "R11 slow memory sequence", bad, 0);
    end
    chk(hold_bad == bh, "R11 address stable while pending", hold_bad - bh, 0);
    ack_lat = 0;

    // R10 reset mid-play keeps registers
    setup(8'h4F, 8'h11, 8'h00);
    b = n_log;
    wr(2'd3, 8'h10);
    wait_log(b + 1, 2000);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(status_o == 8'h00 && !mem_req && !out_valid, "R10 reset mid-play", status_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    b = n_log;
    wr(2'd3, 8'h10);
    wait_log(b + 2, 2000);
    chk(log_a[b%256] == 16'hC440 && log_a[(b+1)%256] == 16'hC440,
        "R10 registers retained", log_a[b%256], 16'hC440);
    wr(2'd3, 8'h00);
    repeat (4) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule